// File: doc/BRIEF.md
# RTC Smooth Calibration Pulse Trimmer

The block sits between the raw real-time-clock tick and the prescaler chain. For each incoming tick it gives a one-cycle enable, except for a programmed number of ticks per calibration window that it removes. It can also add one enable every 2^INS_W ticks. A count of zero with insertion off leaves the tick stream unchanged. A count of M with insertion on changes the rate by (2^(WIN_W-INS_W) x inc) - M pulses per full window. At the default sizes, with a 32768 Hz input, the full window is 32 seconds and each removed pulse is worth about 0.95 ppm.

The window holds 2^WIN_W ticks. A tick is dropped when its bit-reversed position in the window is below the effective count, which spreads the drops evenly. Two shorter window options exist: half length and quarter length. With one of them the low one or two bits of the count read as zero, and each sub-window drops its share. Configuration is written through a strobe and applies only while the unlock input is high. A write that selects both short options is discarded. An accepted setting waits and becomes active at the next window boundary.

Top module: `smoothcal_top`

## Requirements
- R1: After reset, with no configuration written, every input tick gives exactly one enable and no other enables appear.
- R2: With a full window and effective count M, tick n of the window (n counted from 0 after reset in whole windows) is dropped exactly when bitreverse_WIN_W(n) < M. This drops M ticks per window.
- R3: With M at most 2^(WIN_W-1), two consecutive ticks are never both dropped.
- R4: With insertion on, one extra enable follows every tick whose low INS_W bits of the window position are all ones. This gives 2^(WIN_W-INS_W) extras per full window. With insertion off there are none.
- R5: With the half option, mask bit 0 reads as 0. Each half window of 2^(WIN_W-1) ticks drops the ticks whose reversed position, shifted right by 1, is below M>>1.
- R6: With the quarter option, mask bits 1:0 read as 00. Each quarter window uses a right shift of 2 in the same way.
- R7: A write that sets both short-window options is ignored, and the previous setting stays in force.
- R8: A write while cfgUnlock is low is ignored.
- R9: An accepted write becomes active only after the last tick of the current window or sub-window. A window is never run with mixed settings.
- R10: The enable for a kept tick appears in the cycle after that tick. An inserted enable appears in the first cycle after the insertion point whose preceding cycle had no tick, so it never lands on a tick's slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| rtcTick | input | 1 | One-cycle raw oscillator tick, at least two cycles apart |
| cfgWr | input | 1 | Configuration write strobe |
| cfgUnlock | input | 1 | Write protection open when high |
| cfgMask | input | MASK_W | Number of ticks to drop per full window |
| cfgInc | input | 1 | Enable periodic pulse insertion |
| cfgHalf | input | 1 | Select half-length window |
| cfgQuarter | input | 1 | Select quarter-length window |
| clkEnOut | output | 1 | Qualified enable to the prescalers |

## Verification
A kept or dropped tick shows up one cycle after the tick, when the enable is sampled. The bench samples at every falling edge and classifies the sample by the tick that the preceding rising edge saw. A sample that follows a tick is compared with the expected keep or drop for that window position. A sample that follows a tick-free cycle can only be an insertion, and those are counted. A configuration write affects nothing until a window ends, so the bench runs one unchecked window after each write before it checks. The one exception is the deliberate mid-window write, where the current window must still follow the old setting.

// File: rtl/smoothcal_pkg.sv
package smoothcal_pkg;
  // Window length choice; numeric value equals the right shift applied
  typedef enum logic [1:0] {
    WIN_FULL    = 2'd0,
    WIN_HALF    = 2'd1,
    WIN_QUARTER = 2'd2
  } winSel_e;

  typedef struct packed {
    winSel_e winSel;
    logic    incEn;
  } dpCtl_t;
endpackage

// File: rtl/smoothcal_ctrl.sv
module smoothcal_ctrl
  import smoothcal_pkg::*;
#(
  parameter int MASK_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWr,
  input  logic              cfgUnlock,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic              cfgInc,
  input  logic              cfgHalf,
  input  logic              cfgQuarter,
  input  logic              winEnd,
  output dpCtl_t            dpCtl,
  output logic [MASK_W-1:0] effMask
);
  logic [MASK_W-1:0] pendMask, actMask;
  logic              pendInc, actInc;
  winSel_e           pendSel, actSel, wrSel;
  logic              wrAccept;

  assign wrAccept = cfgWr && cfgUnlock && !(cfgHalf && cfgQuarter);
  assign wrSel    = cfgQuarter ? WIN_QUARTER : (cfgHalf ? WIN_HALF : WIN_FULL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendMask <= '0;
      pendInc  <= 1'b0;
      pendSel  <= WIN_FULL;
    end else if (wrAccept) begin
      pendMask <= cfgMask;
      pendInc  <= cfgInc;
      pendSel  <= wrSel;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actMask <= '0;
      actInc  <= 1'b0;
      actSel  <= WIN_FULL;
    end else if (winEnd) begin
      actMask <= pendMask;
      actInc  <= pendInc;
      actSel  <= pendSel;
    end
  end

  always_comb begin
    case (actSel)
      WIN_HALF:    effMask = {actMask[MASK_W-1:1], 1'b0};
      WIN_QUARTER: effMask = {actMask[MASK_W-1:2], 2'b00};
      default:     effMask = actMask;
    endcase
  end

  assign dpCtl.winSel = actSel;
  assign dpCtl.incEn  = actInc;

  // R8: locked write leaves pending setting untouched
  a_r8_locked_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && !cfgUnlock) |=> ($stable(pendMask) && $stable(pendInc) && $stable(pendSel)));

  // R7: write with both short options is discarded
  a_r7_both_sel_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWr && cfgHalf && cfgQuarter) |=> ($stable(pendMask) && $stable(pendInc) && $stable(pendSel)));

  // R9: active setting only moves at a window boundary
  a_r9_hold_mid_window: assert property (@(posedge clk) disable iff (!rstN)
    !winEnd |=> ($stable(actMask) && $stable(actInc) && $stable(actSel)));
endmodule

// File: rtl/smoothcal_dp.sv
module smoothcal_dp
  import smoothcal_pkg::*;
#(
  parameter int WIN_W  = 20,
  parameter int INS_W  = 11,
  parameter int MASK_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  dpCtl_t            dpCtl,
  input  logic [MASK_W-1:0] effMask,
  output logic              winEnd,
  output logic              clkEn
);
  localparam logic [WIN_W-1:0] ALL_ONES = {WIN_W{1'b1}};

  logic [WIN_W-1:0] winCnt, revCnt, lowMask, revShift, maskShift;
  logic             dropNow, insPoint, insPend;

  for (genvar i = 0; i < WIN_W; i++) begin : g_rev
    assign revCnt[i] = winCnt[WIN_W-1-i];
  end

  assign lowMask   = ALL_ONES >> dpCtl.winSel;
  assign revShift  = revCnt >> dpCtl.winSel;
  assign maskShift = WIN_W'(effMask) >> dpCtl.winSel;
  assign dropNow   = tick && (revShift < maskShift);
  assign winEnd    = tick && ((winCnt & lowMask) == lowMask);
  assign insPoint  = tick && dpCtl.incEn && (&winCnt[INS_W-1:0]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      insPend <= 1'b0;
      clkEn   <= 1'b0;
    end else begin
      if (tick) winCnt <= winCnt + 1'b1;
      insPend <= insPoint || (insPend && tick);
      clkEn   <= (tick && !dropNow) || (insPend && !tick);
    end
  end

  // R1: a tick that is not dropped yields an enable next cycle
  a_r1_keep_tick: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !dropNow) |=> clkEn);

  // R10: every enable has a tick or a pending insertion behind it
  a_r10_enable_source: assert property (@(posedge clk) disable iff (!rstN)
    clkEn |-> ($past(tick) || $past(insPend)));

  // R4: pending insertion is issued on the first tick-free cycle
  a_r4_insert_issued: assert property (@(posedge clk) disable iff (!rstN)
    (insPend && !tick) |=> (clkEn && !insPend));

  // R2: a dropped tick yields no enable
  a_r2_drop_silent: assert property (@(posedge clk) disable iff (!rstN)
    (tick && dropNow) |=> !clkEn);
endmodule

// File: rtl/smoothcal_top.sv
module smoothcal_top
  import smoothcal_pkg::*;
#(
  parameter int WIN_W  = 20,
  parameter int INS_W  = 11,
  parameter int MASK_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rtcTick,
  input  logic              cfgWr,
  input  logic              cfgUnlock,
  input  logic [MASK_W-1:0] cfgMask,
  input  logic              cfgInc,
  input  logic              cfgHalf,
  input  logic              cfgQuarter,
  output logic              clkEnOut
);
  dpCtl_t            dpCtl;
  logic [MASK_W-1:0] effMask;
  logic              winEnd;

  smoothcal_ctrl #(.MASK_W(MASK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgUnlock(cfgUnlock),
    .cfgMask(cfgMask), .cfgInc(cfgInc), .cfgHalf(cfgHalf),
    .cfgQuarter(cfgQuarter), .winEnd(winEnd), .dpCtl(dpCtl), .effMask(effMask)
  );

  smoothcal_dp #(.WIN_W(WIN_W), .INS_W(INS_W), .MASK_W(MASK_W)) u_dp (
    .clk(clk), .rstN(rstN), .tick(rtcTick), .dpCtl(dpCtl),
    .effMask(effMask), .winEnd(winEnd), .clkEn(clkEnOut)
  );
endmodule

// File: tb/tb_smoothcal_top.sv
module tb_smoothcal_top;
  localparam int CLK_PERIOD = 10;
  localparam int WIN_W  = 10;
  localparam int INS_W  = 5;
  localparam int MASK_W = 9;
  localparam int WIN_LEN = 1 << WIN_W;

  logic clk = 1'b0, rstN = 1'b0, rtcTick = 1'b0;
  logic cfgWr = 1'b0, cfgUnlock = 1'b0, cfgInc = 1'b0, cfgHalf = 1'b0, cfgQuarter = 1'b0;
  logic [MASK_W-1:0] cfgMask = '0;
  logic clkEnOut;

  int errors = 0, checks = 0;
  // bench model of configuration
  int pendM = 0, pendS = 0, actM = 0, actS = 0;
  bit pendI = 0, actI = 0;
  // per-window observation
  int tickIdx, dropCnt, insCnt, run, maxRun;
  bit measuring;

  always #(CLK_PERIOD/2) clk = ~clk;

  smoothcal_top #(.WIN_W(WIN_W), .INS_W(INS_W), .MASK_W(MASK_W)) dut (
    .clk(clk), .rstN(rstN), .rtcTick(rtcTick), .cfgWr(cfgWr), .cfgUnlock(cfgUnlock),
    .cfgMask(cfgMask), .cfgInc(cfgInc), .cfgHalf(cfgHalf), .cfgQuarter(cfgQuarter),
    .clkEnOut(clkEnOut)
  );

  function automatic int bitrev(input int v);
    int r = 0;
    for (int i = 0; i < WIN_W; i++) if (v[i]) r |= 1 << (WIN_W-1-i);
    return r;
  endfunction

  function automatic int effOf(input int m, input int s);
    return m & ~((1 << s) - 1);
  endfunction

  function automatic bit expDrop(input int idx, input int m, input int s);
    return (bitrev(idx) >> s) < (effOf(m, s) >> s);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one cycle: observe the enable produced by the previous edge, then drive next tick
  task automatic step(input bit t, input string req);
    @(negedge clk);
    if (rtcTick) begin
      bit dr = expDrop(tickIdx, actM, actS);
      if (measuring) check(clkEnOut == !dr, req, clkEnOut, !dr);
      if (!clkEnOut) begin dropCnt++; run++; if (run > maxRun) maxRun = run; end
      else run = 0;
      tickIdx++;
    end else if (clkEnOut) insCnt++;
    rtcTick = t;
  endtask

  task automatic writeCfg(input int m, input bit inc, input bit half, input bit qtr, input bit unl);
    step(0, "cfg");
    cfgWr = 1; cfgMask = MASK_W'(m); cfgInc = inc; cfgHalf = half; cfgQuarter = qtr; cfgUnlock = unl;
    step(0, "cfg");
    cfgWr = 0; cfgUnlock = 0;
    if (unl && !(half && qtr)) begin
      pendM = m; pendI = inc; pendS = qtr ? 2 : (half ? 1 : 0);
    end
  endtask

  // one full window; optional mid-window write
  task automatic runWindow(input bit meas, input string req, input bit midWr, input int midM);
    measuring = meas; tickIdx = 0; dropCnt = 0; insCnt = 0; run = 0; maxRun = 0;
    for (int n = 0; n < WIN_LEN; n++) begin
      step(1, req);
      if (midWr && n == WIN_LEN/3) writeCfg(midM, 0, 0, 0, 1);
      for (int g = 0; g < 1 + int'($urandom % 3); g++) step(0, req);
    end
    for (int g = 0; g < 4; g++) step(0, req);
    if (meas) begin
      check(dropCnt == effOf(actM, actS), {req, " drop total"}, dropCnt, effOf(actM, actS));
      check(insCnt == (actI ? (1 << (WIN_W-INS_W)) : 0), {req, " R4 insert total"},
            insCnt, actI ? (1 << (WIN_W-INS_W)) : 0);
      check(maxRun <= 1, {req, " R3 max drop run"}, maxRun, 1);
    end
    actM = pendM; actI = pendI; actS = pendS;
  endtask

  task automatic cfgAndRun(input int m, input bit inc, input bit half, input bit qtr, input string req);
    writeCfg(m, inc, half, qtr, 1);
    runWindow(0, req, 0, 0);
    runWindow(1, req, 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check(clkEnOut == 0, "R1 reset state", clkEnOut, 0);
    rstN = 1;
    // R1: passthrough after reset
    runWindow(1, "R1", 0, 0);
    // R2 and R3: plain masking, small and maximal counts
    cfgAndRun(5, 0, 0, 0, "R2");
    cfgAndRun(511, 1, 0, 0, "R2 R3 R4");
    // R4: insertion only
    cfgAndRun(0, 1, 0, 0, "R4");
    // R5: half window, bit 0 forced low
    cfgAndRun(7, 0, 1, 0, "R5");
    // R6: quarter window, bits 1:0 forced low
    cfgAndRun(511, 1, 0, 1, "R6");
    // R8: locked write has no effect on the stream
    writeCfg(3, 0, 0, 0, 0);
    runWindow(1, "R8", 0, 0);
    // R7: both short options set, write discarded
    writeCfg(9, 0, 1, 1, 1);
    runWindow(1, "R7", 0, 0);
    // R9: full window active, mid-window write keeps old setting for this window
    cfgAndRun(40, 0, 0, 0, "R9 prep");
    runWindow(1, "R9 old", 1, 100);
    runWindow(1, "R9 new", 0, 0);
    // random configurations, checked per tick (R10 timing of each sample)
    for (int k = 0; k < 4; k++) begin
      int sel = int'($urandom % 3);
      cfgAndRun(int'($urandom % 512), bit'($urandom % 2), sel == 1, sel == 2, "R2 R10 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule